// File: doc/BRIEF.md
# GPIO Bank with Atomic Output Updates

This block is one bank of up to 32 general-purpose I/O lines behind a small 32-bit register bus. Each line can be an input or an output, and each can be logically inverted. Software changes the output latch through dedicated set, clear and toggle registers. It writes a one-hot or multi-bit mask, and only the lines named in the mask change. Two agents can therefore drive different lines with no read-modify-write race.

Pin levels pass through a two-flop synchroniser. They are then read back through the data register and fed to a per-line edge detector. Rising and falling edges have separate enables. An enabled edge sets a sticky status bit that software clears by writing one. The edge record remembers which kind of edge set each bit. One interrupt output is raised while any status bit is set.

The bus is a single-cycle request: `bus_valid` with `bus_write` high writes at the clock edge. `bus_valid` with `bus_write` low is a read, and its result appears on `bus_rdata` with `bus_rvalid` one cycle later.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the direction, polarity, output latch, rising enable, falling enable, status and edge-record registers are all zero, so pin_oe = 0, pin_out = 0 and irq = 0.
- R2: The direction register (offset 0x24) drives pin_oe bit for bit; a 1 makes the line an output, a 0 an input.
- R3: Writing a mask to offset 0x2C sets the latch bit of every line whose mask bit is 1 and leaves every other latch bit unchanged.
- R4: Writing a mask to offset 0x30 clears the latch bit of every line whose mask bit is 1 and leaves every other latch bit unchanged.
- R5: Writing a mask to offset 0x34 inverts the latch bit of every line whose mask bit is 1 and leaves every other latch bit unchanged.
- R6: The polarity register (offset 0x28, 1 = inverted) gives pin_out = latch XOR polarity, and the logical input level = synchronised pin XOR polarity.
- R7: Reading offset 0x20 returns, for output lines, the latch bit and, for input lines, the logical input level; a pin change reaches this view only after two clock edges of synchronisation. Writing offset 0x20 loads the whole latch.
- R8: A logical 0-to-1 transition on a line whose bit in the rising enable (offset 0x08) is 1 sets its status bit (offset 0x00) and sets its edge-record bit (offset 0x04) to 1.
- R9: A logical 1-to-0 transition on a line whose bit in the falling enable (offset 0x0C) is 1 sets its status bit and sets its edge-record bit to 0.
- R10: An edge whose direction is not enabled on that line leaves that line's status and edge-record bits unchanged.
- R11: Writing a mask to offset 0x00 clears the status bits whose mask bit is 1, others stay set; an enabled edge landing in the same cycle as its clear leaves the bit set.
- R12: irq is 1 exactly when at least one status bit is 1.
- R13: A read request returns its data with bus_rvalid one cycle later; offsets 0x2C, 0x30, 0x34 and every unmapped offset read as zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | N_LINES (32) | Asynchronous pin levels |
| pin_out | output | N_LINES (32) | Output levels after polarity |
| pin_oe | output | N_LINES (32) | Output enable per line |
| irq | output | 1 | Combined interrupt |

## Verification
The bench issues set, clear and toggle masks that overlap lines already high. A design that wrote the mask straight into the latch would lose those unmasked bits. It samples the data register in the same cycle a pin changes, so a design that skipped or shortened the synchroniser would return the new level too early. The bench enables only one edge direction per line and then drives both edges. This exposes a design that ignores the enables, or one that overwrites the edge record on unenabled edges. A status clear is also timed to land on the same edge as a new enabled event; a design that gives the clear priority would drop that interrupt.

// File: rtl/gpio_pkg.sv
// Shared offsets and types for the GPIO bank.
// Assumes byte addressing with 32-bit aligned registers.
package gpio_pkg;

    localparam int unsigned BUS_W = 32;

    localparam int unsigned OFS_STAT    = 32'h00;
    localparam int unsigned OFS_EDGE    = 32'h04;
    localparam int unsigned OFS_RISE_EN = 32'h08;
    localparam int unsigned OFS_FALL_EN = 32'h0C;
    localparam int unsigned OFS_DATA    = 32'h20;
    localparam int unsigned OFS_DIR     = 32'h24;
    localparam int unsigned OFS_POL     = 32'h28;
    localparam int unsigned OFS_SET     = 32'h2C;
    localparam int unsigned OFS_CLR     = 32'h30;
    localparam int unsigned OFS_TGL     = 32'h34;

    typedef enum logic [2:0] {
        LATCH_HOLD,
        LATCH_LOAD,
        LATCH_SET,
        LATCH_CLR,
        LATCH_TGL
    } latch_op_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is independent; no cross-bit coherence is promised.
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
// Output latch with whole-word load and masked set, clear and toggle.
// Assumes at most one operation per cycle (the bus carries one address).
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  latch_op_e        op,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] latch_q
);

    logic armed_q;

    // Apply the requested latch operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            unique case (op)
                LATCH_LOAD: latch_q <= mask;
                LATCH_SET:  latch_q <= latch_q | mask;
                LATCH_CLR:  latch_q <= latch_q & ~mask;
                LATCH_TGL:  latch_q <= latch_q ^ mask;
                default:    latch_q <= latch_q;
            endcase
        end
    end

    // Qualify history-based checks until a cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_SET |=> (latch_q & $past(mask)) == $past(mask)); // R3
    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_SET |=> (latch_q & ~$past(mask)) == ($past(latch_q) & ~$past(mask))); // R3
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_CLR |=> (latch_q & $past(mask)) == '0); // R4
    AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_CLR |=> (latch_q & ~$past(mask)) == ($past(latch_q) & ~$past(mask))); // R4
    AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_TGL |=> latch_q == ($past(latch_q) ^ $past(mask))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        op == LATCH_HOLD |=> $stable(latch_q)); // R13

endmodule

// File: rtl/gpio_edge_irq.sv
// Per-line edge detector with sticky status and edge-kind record.
// Assumes level is already synchronised and polarity-corrected.
// A new event wins over a write-one-to-clear in the same cycle.
module gpio_edge_irq #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status_q,
    output logic [WIDTH-1:0] edge_q
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise_hit;
    logic [WIDTH-1:0] fall_hit;
    logic [WIDTH-1:0] any_hit;
    logic [WIDTH-1:0] clr_eff;
    logic             armed_q;

    // Find enabled transitions against last cycle's level.
    always_comb begin
        rise_hit = level & ~prev_q & rise_en;
        fall_hit = ~level & prev_q & fall_en;
        any_hit  = rise_hit | fall_hit;
        clr_eff  = clr_we ? clr_mask : '0;
    end

    // Remember the level, latch status and record the edge kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
            edge_q   <= '0;
        end else begin
            prev_q   <= level;
            status_q <= (status_q & ~clr_eff) | any_hit;
            edge_q   <= (edge_q & ~any_hit) | rise_hit;
        end
    end

    // Qualify history-based checks until a cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_RISE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        |rise_hit |=> (edge_q & status_q & $past(rise_hit)) == $past(rise_hit)); // R8
    AST_FALL_RECORDED: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        |fall_hit |=> (edge_q & $past(fall_hit)) == '0); // R9
    AST_NEW_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ((status_q & ~$past(status_q)) & ~($past(rise_en) | $past(fall_en))) == '0); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        clr_we |=> (status_q & $past(clr_mask) & ~$past(any_hit)) == '0); // R11
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !clr_we |=> (status_q & $past(status_q)) == $past(status_q)); // R11

endmodule

// File: rtl/gpio_bank.sv
// GPIO bank: register decode, direction and polarity, output latch,
// input synchroniser and edge interrupts. Reads return one cycle later.
// Assumes N_LINES <= 32 and one bus request per cycle.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int unsigned N_LINES     = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               bus_rvalid,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] pin_out,
    output logic [N_LINES-1:0] pin_oe,
    output logic               irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE_EN);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL_EN);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_TGL  = ADDR_W'(OFS_TGL);

    logic               wr_en;
    logic               rd_req;
    logic [N_LINES-1:0] mask;
    logic [N_LINES-1:0] dir_q;
    logic [N_LINES-1:0] pol_q;
    logic [N_LINES-1:0] rise_en_q;
    logic [N_LINES-1:0] fall_en_q;
    logic [N_LINES-1:0] latch_q;
    logic [N_LINES-1:0] pin_sync;
    logic [N_LINES-1:0] in_lvl;
    logic [N_LINES-1:0] status_q;
    logic [N_LINES-1:0] edge_q;
    logic [N_LINES-1:0] data_view;
    logic [BUS_W-1:0]   rd_word;
    logic               rd_unmapped;
    latch_op_e          latch_op;
    logic               armed_q;

    assign wr_en  = bus_valid && bus_write;
    assign rd_req = bus_valid && !bus_write;
    assign mask   = bus_wdata[N_LINES-1:0];

    // Control registers written by whole-word stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            pol_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_DIR)  dir_q     <= mask;
            if (bus_addr == A_POL)  pol_q     <= mask;
            if (bus_addr == A_RISE) rise_en_q <= mask;
            if (bus_addr == A_FALL) fall_en_q <= mask;
        end
    end

    // Map bus writes to the latch operation.
    always_comb begin
        latch_op = LATCH_HOLD;
        if (wr_en) begin
            unique case (bus_addr)
                A_DATA:  latch_op = LATCH_LOAD;
                A_SET:   latch_op = LATCH_SET;
                A_CLR:   latch_op = LATCH_CLR;
                A_TGL:   latch_op = LATCH_TGL;
                default: latch_op = LATCH_HOLD;
            endcase
        end
    end

    gpio_out_latch #(.WIDTH(N_LINES)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (latch_op),
        .mask    (mask),
        .latch_q (latch_q)
    );

    gpio_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    assign in_lvl = pin_sync ^ pol_q;

    gpio_edge_irq #(.WIDTH(N_LINES)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (in_lvl),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_we   (wr_en && (bus_addr == A_STAT)),
        .clr_mask (mask),
        .status_q (status_q),
        .edge_q   (edge_q)
    );

    assign pin_out   = latch_q ^ pol_q;
    assign pin_oe    = dir_q;
    assign irq       = |status_q;
    assign data_view = (dir_q & latch_q) | (~dir_q & in_lvl);

    // Select the register addressed by a read.
    always_comb begin
        rd_word     = '0;
        rd_unmapped = 1'b0;
        unique case (bus_addr)
            A_STAT:  rd_word = BUS_W'(status_q);
            A_EDGE:  rd_word = BUS_W'(edge_q);
            A_RISE:  rd_word = BUS_W'(rise_en_q);
            A_FALL:  rd_word = BUS_W'(fall_en_q);
            A_DATA:  rd_word = BUS_W'(data_view);
            A_DIR:   rd_word = BUS_W'(dir_q);
            A_POL:   rd_word = BUS_W'(pol_q);
            A_SET, A_CLR, A_TGL: rd_word = '0;
            default: rd_unmapped = 1'b1;
        endcase
    end

    // Register read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) bus_rdata <= rd_word;
        end
    end

    // Qualify history-based checks until a cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) && armed_q == 1'b0 && rst_n |-> (pin_oe == '0 && !irq)); // R1
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        wr_en && bus_addr == A_DIR |=> pin_oe == $past(mask)); // R2
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        bus_rvalid == $past(rd_req)); // R13
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        rd_req && rd_unmapped |=> bus_rdata == '0); // R13
    AST_IRQ_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $fell(irq) |-> $past(wr_en && bus_addr == A_STAT)); // R12

endmodule

// File: tb/gpio_bank_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module gpio_bank_tb;

    localparam logic [7:0] A_STAT = 8'h00, A_EDGE = 8'h04, A_RISE = 8'h08, A_FALL = 8'h0C;
    localparam logic [7:0] A_DATA = 8'h20, A_DIR = 8'h24, A_POL = 8'h28;
    localparam logic [7:0] A_SET = 8'h2C, A_CLR = 8'h30, A_TGL = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic        bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every returned read.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R13 unexpected read data actual %h expected none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check(pin_oe, 32'h0, "R1 pin_oe");
        check(pin_out, 32'h0, "R1 pin_out");
        check({31'h0, irq}, 32'h0, "R1 irq");
        rd(A_DIR, 32'h0, "R1 dir");
        rd(A_POL, 32'h0, "R1 pol");
        rd(A_RISE, 32'h0, "R1 rise_en");
        rd(A_FALL, 32'h0, "R1 fall_en");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_EDGE, 32'h0, "R1 edge");
        rd(A_DATA, 32'h0, "R1 data");

        // R2 direction
        wr(A_DIR, 32'h0000_FFFF);
        check(pin_oe, 32'h0000_FFFF, "R2 pin_oe");
        rd(A_DIR, 32'h0000_FFFF, "R2 dir readback");

        // R3 set
        wr(A_SET, 32'h0000_00F0);
        check(pin_out, 32'h0000_00F0, "R3 set");
        rd(A_DATA, 32'h0000_00F0, "R3 data");
        wr(A_SET, 32'h0000_0003);
        check(pin_out, 32'h0000_00F3, "R3 unmasked kept");

        // R4 clear
        wr(A_CLR, 32'h0000_0030);
        check(pin_out, 32'h0000_00C3, "R4 clear");
        rd(A_DATA, 32'h0000_00C3, "R4 data");

        // R5 toggle
        wr(A_TGL, 32'h0000_0F0F);
        check(pin_out, 32'h0000_0FCC, "R5 toggle");
        wr(A_TGL, 32'h0000_0F0F);
        check(pin_out, 32'h0000_00C3, "R5 toggle back");

        // R6 polarity
        wr(A_POL, 32'hFFFF_0001);
        check(pin_out, 32'hFFFF_00C2, "R6 pin_out inverted");
        idle(3);
        rd(A_DATA, 32'hFFFF_00C3, "R6 input inverted");
        wr(A_POL, 32'h0);
        idle(3);

        // R7 data load and synchroniser latency
        wr(A_DATA, 32'h1234_5678);
        check(pin_out, 32'h1234_5678, "R7 data load");
        rd(A_DATA, 32'h0000_5678, "R7 mixed view");
        pin_in = 32'hA5A5_0000;
        rd(A_DATA, 32'h0000_5678, "R7 sync latency");
        idle(3);
        rd(A_DATA, 32'hA5A5_5678, "R7 input level");

        // R8 R9 R10 edges
        pin_in = 32'h0;
        idle(4);
        wr(A_RISE, 32'h0001_0000);
        wr(A_FALL, 32'h0002_0000);
        pin_in = 32'h0003_0000;
        idle(4);
        rd(A_STAT, 32'h0001_0000, "R8 R10 rise status");
        rd(A_EDGE, 32'h0001_0000, "R8 edge rising");
        check({31'h0, irq}, 32'h1, "R12 irq set");
        pin_in = 32'h0001_0000;
        idle(4);
        rd(A_STAT, 32'h0003_0000, "R9 fall status");
        rd(A_EDGE, 32'h0001_0000, "R9 edge falling");
        pin_in = 32'h0;
        idle(4);
        rd(A_STAT, 32'h0003_0000, "R10 disabled fall");
        rd(A_EDGE, 32'h0001_0000, "R10 edge kept");

        // R11 R12 clear
        wr(A_STAT, 32'h0001_0000);
        rd(A_STAT, 32'h0002_0000, "R11 partial clear");
        check({31'h0, irq}, 32'h1, "R12 irq held");
        wr(A_STAT, 32'h0002_0000);
        rd(A_STAT, 32'h0, "R11 full clear");
        check({31'h0, irq}, 32'h0, "R12 irq low");

        // R11 event beats a same-cycle clear
        wr(A_RISE, 32'h0005_0000);
        pin_in = 32'h0004_0000;
        idle(2);
        wr(A_STAT, 32'h0004_0000);
        rd(A_STAT, 32'h0004_0000, "R11 set wins");
        wr(A_STAT, 32'h0004_0000);
        rd(A_STAT, 32'h0, "R11 cleared after");

        // R13 write-only and unmapped offsets
        rd(8'h10, 32'h0, "R13 unmapped read");
        rd(A_SET, 32'h0, "R13 set reads zero");
        rd(A_TGL, 32'h0, "R13 toggle reads zero");
        wr(8'h90, 32'hFFFF_FFFF);
        rd(A_DIR, 32'h0000_FFFF, "R13 dir untouched");
        rd(A_POL, 32'h0, "R13 pol untouched");
        check(pin_out, 32'h1234_5678, "R13 latch untouched");

        idle(2);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R13 missing reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule